// File: doc/BRIEF.md
# CAN Interrupt Pending Encoder

This block keeps the interrupt pending flags of a CAN controller: one flag for the error logic and one flag for each message buffer (fifteen by default). The error logic and the buffers raise their flags with single-cycle set pulses. Software clears flags by writing ones to a write-only clear register. A separate code-enable mask decides which pending flags take part in a fixed-priority encoder. The encoder output is an interrupt code made of a request bit and a 4-bit source number. That code is placed in a read-only status word together with a 3-bit node state that is supplied from outside.

The block has no data stream. Its edge is a plain register bus. A write happens on any cycle in which `bus_wr_i` is high, and there is no back-pressure: every write is taken in the cycle it is presented. Reads are combinational from `bus_addr_i`, with no read strobe and no wait state. The register addresses are clear = 0, code-enable = 1 and status = 2. Address 3 reads as zero. The `irq_o` pin carries the request bit for the CPU interrupt line.

Top module: `canirq_encoder_top`

## Requirements
- R1: After reset all pending flags and the whole code-enable mask are 0, `irq_o` is 0, and the status word holds only the node-state field.
- R2: A bus write to address 0 clears each pending flag whose data bit is 1: bit 15 is the error flag and bit k is buffer k. A data bit of 0 leaves its flag unchanged, and a read of address 0 returns 0.
- R3: The code-enable mask at address 1 is written and read back in full. Bit 15 enables the error source and bit k enables buffer k.
- R4: When no pending flag is also enabled, the request bit (status bit 4) is 0 and the source field (status bits 3:0) is 0000.
- R5: An error flag that is both pending and enabled gives request 1 and source 0000, and it outranks every buffer.
- R6: Buffer n that is pending and enabled, and that is the highest-ranked such source, gives request 1 and source n+1, so buffer 14 gives 1111.
- R7: A source that is pending but disabled never shows in the code. Its flag is kept, and it shows as soon as its enable bit is set.
- R8: Among buffers, the lower index has the higher priority.
- R9: When a set pulse and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R10: Status bits 7:5 repeat `node_st_i` unchanged for every encoding (000, 010, 011, 10x, 11x), and bits 15:8 read as 0.
- R11: `irq_o` always equals status bit 4.
- R12: A set pulse or a clear changes the code and `irq_o` in the cycle after the edge that registers it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_err_i | input | 1 | One-cycle set pulse for the error flag |
| set_buf_i | input | NUM_BUF | One-cycle set pulses, bit k for buffer k |
| node_st_i | input | 3 | Node state, passed through to the status word |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 clear, 1 code-enable, 2 status |
| bus_wdata_i | input | NUM_BUF+1 | Write data |
| bus_rdata_o | output | NUM_BUF+1 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request, equal to the status request bit |

## Verification
The bench builds the block with the default of fifteen buffers. With this value the register is 16 bits wide, and the source field reaches its top code 1111 through buffer 14 and its bottom code 0000 through the error source. The bench therefore checks both ends of the code range, a sweep over every buffer, and the rank between the error source and the buffers. It also drives a set and a clear onto the same flag in one cycle, and watches the output one cycle before and one cycle after an update.

// File: rtl/canirq_pkg.sv
package canirq_pkg;
  localparam int NODE_W = 3;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CLR  = 2'd0,
    REG_EN   = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } canirq_reg_e;

  function automatic int src_field_w(input int nbuf);
    return $clog2(nbuf + 1);
  endfunction
endpackage

// File: rtl/canirq_pending.sv
module canirq_pending #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] pend_q
);
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pend_q[g] <= 1'b0;
        else if (set_vec[g])   pend_q[g] <= 1'b1;   // set outranks clear
        else if (clr_vec[g])   pend_q[g] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/canirq_code_mask.sv
module canirq_code_mask #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_stb) en_q <= wdata;
  end
endmodule

// File: rtl/canirq_prio_enc.sv
module canirq_prio_enc #(
  parameter int NUM_BUF = 15,
  localparam int W     = NUM_BUF + 1,
  localparam int IST_W = canirq_pkg::src_field_w(NUM_BUF)
) (
  input  logic [W-1:0]     req,     // MSB = error source
  output logic             hit,
  output logic [IST_W-1:0] src
);
  always_comb begin
    hit = 1'b0;
    src = '0;
    // scan downward so the lowest buffer index is the last to win
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        src = IST_W'(i + 1);
      end
    end
    if (req[W-1]) begin
      hit = 1'b1;
      src = '0;
    end
  end
endmodule

// File: rtl/canirq_encoder_top.sv
module canirq_encoder_top #(
  parameter int NUM_BUF = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_err_i,
  input  logic [NUM_BUF-1:0] set_buf_i,
  input  logic [2:0]         node_st_i,
  input  logic               bus_wr_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [NUM_BUF:0]   bus_wdata_i,
  output logic [NUM_BUF:0]   bus_rdata_o,
  output logic               irq_o
);
  import canirq_pkg::*;

  localparam int W     = NUM_BUF + 1;
  localparam int IST_W = src_field_w(NUM_BUF);
  localparam int ST_LO = IST_W + 1 + NODE_W;

  logic [W-1:0]     set_vec, clr_vec, pend_q, en_q, req;
  logic             en_wr, hit;
  logic [IST_W-1:0] src;
  logic [W-1:0]     status;

  assign set_vec = {set_err_i, set_buf_i};
  assign clr_vec = (bus_wr_i && bus_addr_i == REG_CLR) ? bus_wdata_i : '0;
  assign en_wr   = bus_wr_i && (bus_addr_i == REG_EN);

  canirq_pending #(.W(W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  canirq_code_mask #(.W(W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_stb(en_wr), .wdata(bus_wdata_i), .en_q(en_q)
  );

  assign req = pend_q & en_q;

  canirq_prio_enc #(.NUM_BUF(NUM_BUF)) u_enc (
    .req(req), .hit(hit), .src(src)
  );

  generate
    if (W > ST_LO) begin : g_pad
      assign status = {{(W-ST_LO){1'b0}}, node_st_i, hit, src};
    end else begin : g_nopad
      assign status = {node_st_i, hit, src};
    end
  endgenerate

  always_comb begin
    unique case (bus_addr_i)
      REG_EN:   bus_rdata_o = en_q;
      REG_STAT: bus_rdata_o = status;
      default:  bus_rdata_o = '0;   // clear register is write-only
    endcase
  end

  assign irq_o = hit;
endmodule

// File: rtl/canirq_checker.sv
module canirq_checker #(
  parameter int NUM_BUF = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               set_err_i,
  input logic [NUM_BUF-1:0] set_buf_i,
  input logic               bus_wr_i,
  input logic [1:0]         bus_addr_i,
  input logic [NUM_BUF:0]   bus_wdata_i,
  input logic [NUM_BUF:0]   pend_q,
  input logic [NUM_BUF:0]   en_q,
  input logic [NUM_BUF:0]   status,
  input logic [2:0]         node_st_i,
  input logic               irq_o
);
  localparam int T = NUM_BUF;

  a_r9_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_err_i |=> pend_q[T]);

  a_r9_buf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_buf_i) |=> ((pend_q[T-1:0] & $past(set_buf_i)) == $past(set_buf_i)));

  a_r2_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i[T] && !set_err_i) |=> !pend_q[T]);

  a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == 2'd1) |=> (en_q == $past(bus_wdata_i)));

  a_r7_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_q & en_q)));

  a_r4_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_q & en_q)) |-> (!irq_o && status[3:0] == 4'd0));

  a_r5_error_code: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[T] && en_q[T]) |-> (irq_o && status[3:0] == 4'd0));

  a_r10_node_pass: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:5] == node_st_i);
endmodule

bind canirq_encoder_top canirq_checker #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_err_i(set_err_i), .set_buf_i(set_buf_i),
  .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
  .pend_q(pend_q), .en_q(en_q), .status(status), .node_st_i(node_st_i),
  .irq_o(irq_o)
);

// File: tb/canirq_encoder_top_tb_top.sv
`timescale 1ns/1ps
module canirq_encoder_top_tb_top;
  localparam int NB = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_err = 1'b0;
  logic [NB-1:0] set_buf = '0;
  logic [2:0]    node_st = 3'b000;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  canirq_encoder_top #(.NUM_BUF(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_err_i(set_err), .set_buf_i(set_buf),
    .node_st_i(node_st), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] stat(input logic [2:0] n, input logic q, input logic [3:0] s);
    return {8'h00, n, q, s};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input logic e, input logic [NB-1:0] b);
    set_err = e; set_buf = b;
    step();
    set_err = 1'b0; set_buf = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd1, d); chk("R1 mask after reset", d, 16'h0000);
    rd(2'd2, d); chk("R1 status after reset", d, 16'h0000);
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] d;
    wr(2'd1, 16'hA5C3); rd(2'd1, d); chk("R3 mask readback", d, 16'hA5C3);
    wr(2'd1, 16'h5A3C); rd(2'd1, d); chk("R3 mask readback 2", d, 16'h5A3C);
    rd(2'd2, d); chk("R4 no pending code", d, 16'h0000);
  endtask

  task automatic t_sweep();
    logic [15:0] d;
    wr(2'd1, 16'hFFFF);
    for (int n = 0; n < NB; n++) begin
      pulse(1'b0, NB'(1) << n);
      rd(2'd2, d); chk("R6 buffer code", d, stat(3'b000, 1'b1, 4'(n + 1)));
      chk("R11 irq follows request bit", {15'd0, irq}, {15'd0, d[4]});
      wr(2'd0, 16'(1) << n);
      rd(2'd2, d); chk("R2 buffer cleared", d, 16'h0000);
    end
  endtask

  task automatic t_error();
    logic [15:0] d;
    pulse(1'b1, 15'h0008);
    rd(2'd2, d); chk("R5 error outranks buffer", d, stat(3'b000, 1'b1, 4'd0));
    wr(2'd0, 16'h8000);
    rd(2'd2, d); chk("R2 error cleared, buffer 3 left", d, stat(3'b000, 1'b1, 4'd4));
    wr(2'd0, 16'h0008);
    rd(2'd2, d); chk("R2 all cleared", d, 16'h0000);
  endtask

  task automatic t_priority();
    logic [15:0] d;
    pulse(1'b0, 15'h1220);   // buffers 5, 9, 12
    rd(2'd2, d); chk("R8 lowest buffer wins", d, stat(3'b000, 1'b1, 4'd6));
    wr(2'd0, 16'h0000);
    rd(2'd2, d); chk("R2 zero write no effect", d, stat(3'b000, 1'b1, 4'd6));
    wr(2'd0, 16'h0020);
    rd(2'd2, d); chk("R8 next buffer", d, stat(3'b000, 1'b1, 4'd10));
    rd(2'd0, d); chk("R2 clear reg reads zero", d, 16'h0000);
    wr(2'd0, 16'hFFFF);
    rd(2'd2, d); chk("R2 clear all", d, 16'h0000);
  endtask

  task automatic t_disabled();
    logic [15:0] d;
    wr(2'd1, 16'h0000);
    pulse(1'b1, 15'h0004);
    rd(2'd2, d); chk("R7 disabled sources hidden", d, 16'h0000);
    chk("R7 irq low while disabled", {15'd0, irq}, 16'd0);
    wr(2'd1, 16'h0004);
    rd(2'd2, d); chk("R7 buffer 2 kept pending", d, stat(3'b000, 1'b1, 4'd3));
    wr(2'd1, 16'hFFFF);
    rd(2'd2, d); chk("R7 error kept pending", d, stat(3'b000, 1'b1, 4'd0));
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'hFFFF;
    set_buf = 15'h0080; set_err = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0; set_buf = '0; set_err = 1'b0;
    rd(2'd2, d); chk("R9 set beats clear (error)", d, stat(3'b000, 1'b1, 4'd0));
    wr(2'd0, 16'h8000);
    rd(2'd2, d); chk("R9 set beats clear (buffer 7)", d, stat(3'b000, 1'b1, 4'd8));
    wr(2'd0, 16'hFFFF);
  endtask

  task automatic t_timing();
    logic [15:0] d;
    set_buf = 15'h4000;
    #1; chk("R12 irq not yet raised", {15'd0, irq}, 16'd0);
    step();
    set_buf = '0;
    rd(2'd2, d); chk("R12 buffer 14 code next cycle", d, stat(3'b000, 1'b1, 4'hF));
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h4000;
    #1; chk("R12 irq held before clear edge", {15'd0, irq}, 16'd1);
    step();
    bus_wr = 1'b0; bus_wdata = '0;
    chk("R12 irq low after clear edge", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_node();
    logic [15:0] d;
    logic [2:0] codes [5] = '{3'b000, 3'b010, 3'b011, 3'b101, 3'b111};
    pulse(1'b0, 15'h0001);
    foreach (codes[i]) begin
      node_st = codes[i];
      rd(2'd2, d); chk("R10 node state passthrough", d, stat(codes[i], 1'b1, 4'd1));
    end
    wr(2'd0, 16'hFFFF);
    node_st = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_sweep();
    t_error();
    t_priority();
    t_disabled();
    t_set_wins();
    t_timing();
    t_node();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule